// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from a host controller to a PS/2 keyboard over the two open-collector lines. It never drives a line high: it has one pull-low enable per line and reads both lines back as inputs. A one-cycle `start` strobe with `cmd_byte` begins a command. The block first holds the clock line low to inhibit the device. It then pulls data low while the clock is still held and releases the clock, which is the request to send. From that point the keyboard generates every clock edge. The block changes data only after it has seen a falling clock edge. It sends the eight data bits least significant first, then an odd-parity bit, then releases data for the stop slot. It samples the keyboard's acknowledge at the eleventh falling edge.

Exactly one result is reported per command, as a one-cycle pulse on `done`, `ack_err` or `tmo_err`. Both lines are released before that pulse. All timing windows are counted in pulses of the `tick` enable, so the owner of the block chooses the time base. Each line input passes through a two-flop synchronizer and a majority-free glitch filter. The filter accepts a new level only after `FILT_LEN` consecutive equal samples.

The state machine uses these states:
- ST_IDLE goes to ST_INHIBIT on `start`.
- ST_INHIBIT goes to ST_REQUEST after `INHIBIT_TICKS` ticks.
- ST_REQUEST goes to ST_WAIT_CLK on the next tick.
- ST_WAIT_CLK goes to ST_SHIFT on the first falling clock edge, or to ST_FINISH on the first-clock timeout.
- ST_SHIFT goes to ST_ACK on the tenth falling edge, or to ST_FINISH on the transfer timeout.
- ST_ACK goes to ST_FINISH on the eleventh falling edge or on the transfer timeout.
- ST_FINISH goes to ST_IDLE after one cycle.

If a timeout and a clock edge are seen in the same cycle, the timeout wins.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, `busy`, `done`, `ack_err`, `tmo_err`, `kbd_clk_pull` and `kbd_dat_pull` are all 0.
- R2: A `start` in idle pulls the clock line low. The clock stays pulled, with data not pulled, for at least `INHIBIT_TICKS` tick pulses and no more than one tick longer.
- R3: Data is pulled low while the clock is still pulled. The clock pull is released only while the data pull stays asserted, and this forms the start condition.
- R4: The eight data bits go out least significant first, one per falling clock edge. The first bit is presented after the first falling edge, and the data pull changes only while the filtered clock line is low.
- R5: After the eighth data bit, at the ninth falling edge, the block presents a parity bit equal to the inverse XOR of the eight bits, so the nine bits hold an odd number of ones.
- R6: At the tenth falling edge the data pull is released for the stop slot, whatever the device does afterwards.
- R7: At the eleventh falling edge, a low data line gives a `done` pulse and a high data line gives an `ack_err` pulse.
- R8: If no falling clock edge arrives within `FIRST_CLK_TICKS` ticks after the clock is released, the block pulses `tmo_err` and releases both lines.
- R9: If the eleventh falling edge has not arrived `XFER_TICKS` ticks after the first one, the block pulses `tmo_err` and releases both lines. A timeout takes priority over an edge in the same cycle.
- R10: Every accepted command ends in exactly one single-cycle pulse on one of `done`, `ack_err` or `tmo_err`. `busy` falls in the next cycle.
- R11: `start` is ignored while `busy` is high. The byte on the line is the one latched at acceptance.
- R12: A clock-line pulse shorter than `FILT_LEN` system clocks is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing enable, one pulse per time unit |
| start | input | 1 | Begin a command (accepted only in idle) |
| cmd_byte | input | 8 | Command byte to send |
| kbd_clk_in | input | 1 | Level read back from the clock line |
| kbd_dat_in | input | 1 | Level read back from the data line |
| kbd_clk_pull | output | 1 | 1 pulls the clock line low |
| kbd_dat_pull | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: command acknowledged |
| ack_err | output | 1 | One-cycle pulse: acknowledge missing |
| tmo_err | output | 1 | One-cycle pulse: first-clock or transfer timeout |

## Verification
The eleventh falling edge, which samples the acknowledge, can land in the same cycle as the end of the transfer window. The bench provokes this by sweeping the keyboard model's clock half-period across the point where ten periods equal `XFER_TICKS`. For each run it requires exactly one result pulse. It requires `done` well below the boundary and `tmo_err` well above it, and no return to `done` once a timeout has been seen as the period grows. The main sweep sends every third byte value through the keyboard model, which decodes the frame and compares it against bits and parity computed in the bench.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INHIBIT,
        ST_REQUEST,
        ST_WAIT_CLK,
        ST_SHIFT,
        ST_ACK,
        ST_FINISH
    } tx_state_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_NOACK,
        RES_TMO
    } tx_result_e;

    localparam int LAST_SHIFT_IDX = 9;

endpackage

// File: rtl/ps2tx_line_filter.sv
module ps2tx_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
            level  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                level <= 1'b1;
            else if (~|hist_q)
                level <= 1'b0;
        end
    end

    // R12: the filtered level moves only after the synchronized input held steady
    a_r12_filter_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> ($past(sync_q[1], 2) == $past(sync_q[1], 3)));

endmodule

// File: rtl/ps2tx_tick_timer.sv
module ps2tx_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (tick && !(&count))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
    import ps2tx_pkg::*;
#(
    parameter int INHIBIT_TICKS   = 100,
    parameter int FIRST_CLK_TICKS = 20000,
    parameter int XFER_TICKS      = 2000,
    parameter int FILT_LEN        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] cmd_byte,
    input  logic       kbd_clk_in,
    input  logic       kbd_dat_in,
    output logic       kbd_clk_pull,
    output logic       kbd_dat_pull,
    output logic       busy,
    output logic       done,
    output logic       ack_err,
    output logic       tmo_err
);
    localparam int MAX_A = (FIRST_CLK_TICKS > XFER_TICKS) ? FIRST_CLK_TICKS : XFER_TICKS;
    localparam int MAX_T = (MAX_A > INHIBIT_TICKS) ? MAX_A : INHIBIT_TICKS;
    localparam int TW    = $clog2(MAX_T + 2);
    localparam int NLINE = 2;

    // ---- line conditioning ------------------------------------------------
    logic [NLINE-1:0] line_raw;
    logic [NLINE-1:0] line_lvl;
    assign line_raw = {kbd_dat_in, kbd_clk_in};

    for (genvar g = 0; g < NLINE; g++) begin : g_filt
        ps2tx_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (line_raw[g]),
            .level   (line_lvl[g])
        );
    end

    logic clk_lvl, dat_lvl, clk_prev, clk_fall;
    assign clk_lvl  = line_lvl[0];
    assign dat_lvl  = line_lvl[1];
    assign clk_fall = clk_prev & ~clk_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= clk_lvl;
    end

    // ---- state and timer --------------------------------------------------
    tx_state_e     state, nstate;
    logic [TW-1:0] tcnt;
    logic          tmr_clr;
    logic          tmo_now;

    ps2tx_tick_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clr),
        .tick  (tick),
        .count (tcnt)
    );

    always_comb begin
        tmo_now = 1'b0;
        unique case (state)
            ST_WAIT_CLK:     tmo_now = (tcnt >= TW'(FIRST_CLK_TICKS));
            ST_SHIFT, ST_ACK: tmo_now = (tcnt >= TW'(XFER_TICKS));
            default:         tmo_now = 1'b0;
        endcase
    end

    logic [3:0] bit_idx;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (start) nstate = ST_INHIBIT;
            ST_INHIBIT:  if (tcnt >= TW'(INHIBIT_TICKS)) nstate = ST_REQUEST;
            ST_REQUEST:  if (tick) nstate = ST_WAIT_CLK;
            ST_WAIT_CLK: begin
                if (tmo_now)       nstate = ST_FINISH;
                else if (clk_fall) nstate = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tmo_now) nstate = ST_FINISH;
                else if (clk_fall && bit_idx == 4'(LAST_SHIFT_IDX)) nstate = ST_ACK;
            end
            ST_ACK: begin
                if (tmo_now || clk_fall) nstate = ST_FINISH;
            end
            ST_FINISH:   nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // the transfer window runs on through the acknowledge slot
    assign tmr_clr = (nstate != state) && (nstate != ST_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // ---- datapath ---------------------------------------------------------
    logic [7:0]  sh_byte;
    logic        par_bit;
    logic        tx_bit;
    tx_result_e  res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_byte <= '0;
            par_bit <= 1'b1;
            tx_bit  <= 1'b1;
            bit_idx <= '0;
            res     <= RES_OK;
        end else begin
            if (state == ST_IDLE && start) begin
                sh_byte <= cmd_byte;
                par_bit <= ~(^cmd_byte);
            end
            if (state == ST_WAIT_CLK && clk_fall && !tmo_now) begin
                tx_bit  <= sh_byte[0];
                bit_idx <= 4'd1;
            end
            if (state == ST_SHIFT && clk_fall && !tmo_now) begin
                if (bit_idx < 4'd8)
                    tx_bit <= sh_byte[bit_idx[2:0]];
                else if (bit_idx == 4'd8)
                    tx_bit <= par_bit;
                else
                    tx_bit <= 1'b1;
                bit_idx <= bit_idx + 4'd1;
            end
            if (nstate == ST_FINISH && state != ST_FINISH) begin
                if (tmo_now)      res <= RES_TMO;
                else if (dat_lvl) res <= RES_NOACK;
                else              res <= RES_OK;
            end
        end
    end

    // ---- outputs ----------------------------------------------------------
    always_comb begin
        busy         = (state != ST_IDLE);
        kbd_clk_pull = 1'b0;
        kbd_dat_pull = 1'b0;
        done         = 1'b0;
        ack_err      = 1'b0;
        tmo_err      = 1'b0;
        unique case (state)
            ST_INHIBIT:  kbd_clk_pull = 1'b1;
            ST_REQUEST:  begin kbd_clk_pull = 1'b1; kbd_dat_pull = 1'b1; end
            ST_WAIT_CLK: kbd_dat_pull = 1'b1;
            ST_SHIFT:    kbd_dat_pull = ~tx_bit;
            ST_FINISH: begin
                done    = (res == RES_OK);
                ack_err = (res == RES_NOACK);
                tmo_err = (res == RES_TMO);
            end
            default: ;
        endcase
    end

    // R3: the clock is let go only while data is held low
    a_r3_clock_release_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(kbd_clk_pull) && busy) |-> kbd_dat_pull);

    // R4: data moves only while the line clock is low
    a_r4_data_changes_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT && !$stable(kbd_dat_pull)) |-> !clk_lvl);

    // R7: success is reported only after a low data line at the last edge
    a_r7_ack_seen_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(dat_lvl));

    // R10: a result is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || ack_err || tmo_err) |=> !(done || ack_err || tmo_err));

endmodule

// File: tb/ps2_cmd_tx_tb.sv
module ps2_cmd_tx_tb;
    localparam int TICK_DIV = 4;
    localparam int INH      = 4;
    localparam int FIRST    = 60;
    localparam int XFER     = 150;
    localparam int FILT     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic start = 1'b0;
    logic [7:0] cmd = '0;
    logic dev_clk_low = 1'b0;
    logic dev_dat_low = 1'b0;
    logic clk_pull, dat_pull, busy, done, ack_err, tmo_err;
    logic clk_line, dat_line;

    int errors = 0;
    int checks = 0;
    int n_done = 0, n_nack = 0, n_tmo = 0;
    int inh_cnt = 0, last_inh = -1;
    logic [1:0] div = '0;

    assign clk_line = ~(clk_pull | dev_clk_low);
    assign dat_line = ~(dat_pull | dev_dat_low);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'(TICK_DIV - 1));
    end

    ps2_cmd_tx #(
        .INHIBIT_TICKS(INH), .FIRST_CLK_TICKS(FIRST),
        .XFER_TICKS(XFER), .FILT_LEN(FILT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .cmd_byte(cmd),
        .kbd_clk_in(clk_line), .kbd_dat_in(dat_line),
        .kbd_clk_pull(clk_pull), .kbd_dat_pull(dat_pull),
        .busy(busy), .done(done), .ack_err(ack_err), .tmo_err(tmo_err)
    );

    always @(negedge clk) begin
        if (done)    n_done++;
        if (ack_err) n_nack++;
        if (tmo_err) n_tmo++;
        if (clk_pull && !dat_pull) inh_cnt++;
        if (clk_pull && dat_pull && inh_cnt != 0) begin
            last_inh = inh_cnt;
            inh_cnt  = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // keyboard model: returns the ten bits it read after each falling edge
    task automatic dev_xfer(input int h, input bit give_ack, input bit glitch,
                            output logic [9:0] got, output bit saw_req);
        saw_req = 1'b0;
        got = '0;
        for (int w = 0; w < 600 && !saw_req; w++) begin
            @(negedge clk);
            if (!clk_pull && dat_pull) saw_req = 1'b1;
        end
        if (!saw_req) return;
        repeat (10) @(negedge clk);
        for (int k = 1; k <= 11; k++) begin
            dev_clk_low = 1'b1;
            repeat (h) @(negedge clk);
            dev_clk_low = 1'b0;
            if (glitch && k == 4) begin
                repeat (3) @(negedge clk);
                dev_clk_low = 1'b1;
                @(negedge clk);
                dev_clk_low = 1'b0;
            end
            repeat (h / 2) @(negedge clk);
            if (k <= 10) got[k-1] = dat_line;
            if (k == 10 && give_ack) dev_dat_low = 1'b1;
            repeat (h - h / 2) @(negedge clk);
        end
        dev_dat_low = 1'b0;
    endtask

    // outcome: 0 done, 1 ack missing, 2 timeout, 3 none or several
    task automatic run_cmd(input logic [7:0] v, input int h, input bit give_ack,
                           input bit glitch, input bit use_dev,
                           output logic [9:0] got, output int outc, output bit saw_req);
        int d0, a0, t0;
        d0 = n_done; a0 = n_nack; t0 = n_tmo;
        @(negedge clk);
        cmd = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (use_dev) dev_xfer(h, give_ack, glitch, got, saw_req);
        else begin
            got = '0; saw_req = 1'b0;
            repeat (FIRST * TICK_DIV + 120) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        if (n_done - d0 == 1 && n_nack == a0 && n_tmo == t0)      outc = 0;
        else if (n_nack - a0 == 1 && n_done == d0 && n_tmo == t0) outc = 1;
        else if (n_tmo - t0 == 1 && n_done == d0 && n_nack == a0) outc = 2;
        else outc = 3;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0] got;
        int outc;
        bit saw;
        bit seen_tmo;

        repeat (3) @(negedge clk);
        chk({busy, done, ack_err, tmo_err, clk_pull, dat_pull} == 6'b0, "R1 reset outputs",
            int'({busy, done, ack_err, tmo_err, clk_pull, dat_pull}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && !clk_pull && !dat_pull, "R1 idle after reset", int'(busy), 0);

        // main sweep: every third byte value
        for (int v = 0; v < 256; v += 3) begin
            logic [7:0] b;
            b = 8'(v);
            run_cmd(b, 26, 1'b1, 1'b0, 1'b1, got, outc, saw);
            chk(saw, "R3 request seen", int'(saw), 1);
            chk(got[7:0] == b, "R4 byte lsb first", int'(got[7:0]), v);
            chk(got[8] == ~(^b), "R5 parity bit", int'(got[8]), int'(~(^b)));
            chk(($countones(got[8:0]) % 2) == 1, "R5 odd ones", $countones(got[8:0]), 1);
            chk(got[9] == 1'b1, "R6 stop released", int'(got[9]), 1);
            chk(outc == 0, "R7 done on ack", outc, 0);
            chk(!busy, "R10 busy cleared", int'(busy), 0);
        end
        chk(last_inh >= (INH - 1) * TICK_DIV + 1 && last_inh <= (INH + 1) * TICK_DIV + 1,
            "R2 inhibit length", last_inh, INH * TICK_DIV);

        // no acknowledge
        run_cmd(8'hED, 26, 1'b0, 1'b0, 1'b1, got, outc, saw);
        chk(outc == 1, "R7 ack missing", outc, 1);
        chk(got[9] == 1'b1, "R6 stop released without ack", int'(got[9]), 1);

        // no clock at all
        run_cmd(8'hF4, 26, 1'b1, 1'b0, 1'b0, got, outc, saw);
        chk(outc == 2, "R8 first clock timeout", outc, 2);
        chk(!clk_pull && !dat_pull, "R8 lines released", int'({clk_pull, dat_pull}), 0);

        // keyboard too slow
        run_cmd(8'hFF, 40, 1'b1, 1'b0, 1'b1, got, outc, saw);
        chk(outc == 2, "R9 transfer timeout", outc, 2);
        chk(!clk_pull && !dat_pull, "R9 lines released", int'({clk_pull, dat_pull}), 0);

        // start while busy
        fork
            run_cmd(8'h3C, 26, 1'b1, 1'b0, 1'b1, got, outc, saw);
            begin
                repeat (200) @(negedge clk);
                cmd = 8'hC3; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        chk(got[7:0] == 8'h3C, "R11 byte kept", int'(got[7:0]), 'h3C);
        chk(outc == 0, "R11 single result", outc, 0);
        repeat (30) @(negedge clk);
        chk(!busy && !clk_pull, "R11 no second command", int'(busy), 0);

        // short glitch on the clock line
        run_cmd(8'hA5, 26, 1'b1, 1'b1, 1'b1, got, outc, saw);
        chk(got[7:0] == 8'hA5, "R12 glitch ignored", int'(got[7:0]), 'hA5);
        chk(outc == 0, "R12 glitch result", outc, 0);

        // boundary: acknowledge edge against transfer window
        seen_tmo = 1'b0;
        for (int h = 26; h <= 34; h++) begin
            run_cmd(8'h5A, h, 1'b1, 1'b0, 1'b1, got, outc, saw);
            chk(outc == 0 || outc == 2, "R10 exactly one result", outc, 0);
            if (20 * h <= 20 * 28) chk(outc == 0, "R9 inside window", outc, 0);
            if (20 * h >= 20 * 32) chk(outc == 2, "R9 outside window", outc, 2);
            if (seen_tmo) chk(outc == 2, "R9 monotonic window", outc, 2);
            if (outc == 2) seen_tmo = 1'b1;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule